// File: doc/BRIEF.md
# Eight-Bit Bidirectional GPIO Port

The block is an 8-bit general-purpose I/O port for a small microcontroller. Software reaches it over a simple register bus: an address, a write strobe with write data, and a read strobe whose data comes back one clock later. Three locations are decoded. The first is an output latch. The second is a direction register. The third is a read-only window onto the synchronized pad levels.

For every pin the block drives three signals toward the pad: an output enable, an output level and a pull-up enable. On an input pin, the latch bit selects the weak pull-up. On an output pin, the latch bit sets the driven level.

Three pins can be taken over by other functions:
- Bit 7 can carry the external-memory read strobe.
- Bit 6 can carry the external-memory write strobe.
- Bit 5 can carry the timer compare output.

A reset tri-states every pin at once, without waiting for a clock edge.

Top module: `gpio_port8`

## Requirements
- R1: After reset, reads of the latch (address 0x12) and the direction register (address 0x11) both return 0x00.
- R2: A write to address 0x12 stores the latch, and a write to 0x11 stores the direction. Each reads back the value written.
- R3: A read of address 0x10 returns the pad levels through a two-stage synchronizer. A pad change made just before the first of two idle clocks is seen by a read issued after those clocks. A read issued after only one idle clock still returns the old level. Writes to 0x10 change neither the latch nor the direction.
- R4: Each ordinary pin (bit i) behaves as follows:
  - direction 1: output enable is on and the output level equals latch bit i;
  - direction 0 with latch 1: pull-up only;
  - direction 0 with latch 0: neither output enable nor pull-up;
  - output enable and pull-up are never on together.
- R5: While reset is high, every output enable and every pull-up is 0. This takes effect without any clock edge.
- R6: While the external-memory enable is high, bits 7 and 6 are forced to outputs. Bit 7 drives the read strobe and bit 6 drives the write strobe, and both have the pull-up off, whatever the latch and direction hold.
- R7: With the timer output enable high and direction bit 5 set to 1, bit 5 drives the timer compare level. With direction bit 5 at 0, the timer output has no effect on bit 5.
- R8: Read data appears on the clock after the read strobe. Unmapped addresses read 0x00, and a clock with no read strobe leaves the read data at 0x00.
- R9: A read and a write to the same address in the same clock return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; pad controls are gated asynchronously |
| bus_addr | input | 6 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| xmem_en | input | 1 | External-memory strobes take over bits 7 and 6 |
| xmem_rd_n | input | 1 | External-memory read strobe level |
| xmem_wr_n | input | 1 | External-memory write strobe level |
| tmr_oc_en | input | 1 | Timer compare output requested on bit 5 |
| tmr_oc_val | input | 1 | Timer compare output level |

## Verification
Two situations need a same-cycle check.

The first is a bus read and a bus write to the same register in the same clock. The bench provokes it with a directed transfer to the latch. It expects the read to return the old latch contents, and a following read to return the new value.

The second is a pin-direction change that coincides with an override. Random stimulus toggles the external-memory and timer overrides while it rewrites the direction and latch registers. After every write, the three pad vectors are compared with a bench model, so each override is judged against the register values just stored.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_W = 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_PIN   = 6'h10;
    localparam logic [ADDR_W-1:0] A_DIR   = 6'h11;
    localparam logic [ADDR_W-1:0] A_LATCH = 6'h12;

    localparam int RD_BIT = 7;
    localparam int WR_BIT = 6;
    localparam int OC_BIT = 5;

    typedef struct packed {
        logic oe;
        logic val;
        logic pu;
    } pad_ctl_t;

    // override request for one pin: enable, level, and whether it forces drive
    typedef struct packed {
        logic en;
        logic val;
        logic drive;
    } alt_fn_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LATCH,
        SEL_DIR,
        SEL_PIN
    } rd_sel_t;

    function automatic rd_sel_t decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            A_LATCH: return SEL_LATCH;
            A_DIR:   return SEL_DIR;
            A_PIN:   return SEL_PIN;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic pad_ctl_t resolve_pin(logic dir, logic lat, alt_fn_t alt);
        pad_ctl_t c;
        c.oe  = dir | (alt.en & alt.drive);
        c.val = alt.en ? alt.val : lat;
        c.pu  = ~c.oe & lat & ~alt.en;
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W  = GPIO_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [W-1:0]  pin_lvl,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  rdata
);
    rd_sel_t      sel;
    logic [W-1:0] rd_mux;

    assign sel = decode_addr(addr);

    always_comb begin
        case (sel)
            SEL_LATCH: rd_mux = latch_q;
            SEL_DIR:   rd_mux = dir_q;
            SEL_PIN:   rd_mux = pin_lvl;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            rdata   <= '0;
        end else begin
            if (we && sel == SEL_LATCH) latch_q <= wdata;
            if (we && sel == SEL_DIR)   dir_q   <= wdata;
            rdata <= re ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic                rst,
    input  logic [W-1:0]        dir,
    input  logic [W-1:0]        lat,
    input  alt_fn_t [W-1:0]     alt,
    output logic [W-1:0]        oe,
    output logic [W-1:0]        val,
    output logic [W-1:0]        pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_ctl_t c;
        assign c     = resolve_pin(dir[i], lat[i], alt[i]);
        assign oe[i]  = ~rst & c.oe;
        assign val[i] = ~rst & c.val;
        assign pu[i]  = ~rst & c.pu;
    end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
    import gpio_pkg::*;
#(
    parameter int W  = GPIO_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_re,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_pu,
    input  logic          xmem_en,
    input  logic          xmem_rd_n,
    input  logic          xmem_wr_n,
    input  logic          tmr_oc_en,
    input  logic          tmr_oc_val
);
    logic [W-1:0]    pin_lvl;
    logic [W-1:0]    latch_q;
    logic [W-1:0]    dir_q;
    alt_fn_t [W-1:0] alt;

    gpio_sync #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_lvl)
    );

    gpio_regs #(.W(W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .re      (bus_re),
        .pin_lvl (pin_lvl),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .rdata   (bus_rdata)
    );

    always_comb begin
        alt = '0;
        alt[RD_BIT] = '{en: xmem_en, val: xmem_rd_n, drive: 1'b1};
        alt[WR_BIT] = '{en: xmem_en, val: xmem_wr_n, drive: 1'b1};
        alt[OC_BIT] = '{en: tmr_oc_en & dir_q[OC_BIT], val: tmr_oc_val, drive: 1'b0};
    end

    gpio_pin_ctl #(.W(W)) u_pins (
        .rst (rst),
        .dir (dir_q),
        .lat (latch_q),
        .alt (alt),
        .oe  (pad_oe),
        .val (pad_out),
        .pu  (pad_pu)
    );
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [GPIO_W-1:0] bus_rdata,
    input logic [GPIO_W-1:0] pad_oe,
    input logic [GPIO_W-1:0] pad_out,
    input logic [GPIO_W-1:0] pad_pu,
    input logic              xmem_en,
    input logic              xmem_rd_n,
    input logic              xmem_wr_n,
    input logic              tmr_oc_en,
    input logic              tmr_oc_val,
    input logic [GPIO_W-1:0] latch_q,
    input logic [GPIO_W-1:0] dir_q
);
    // R5: reset holds every pad released
    always @(negedge clk) begin
        if (rst === 1'b1) begin
            a_r5_reset_tristate: assert (pad_oe == '0 && pad_pu == '0);
        end
    end

    a_r4_no_drive_with_pullup: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (pad_oe & pad_pu) == '0);

    a_r6_xmem_takeover: assert property (@(posedge clk) disable iff (rst)
        xmem_en |-> (pad_oe[RD_BIT] && pad_oe[WR_BIT] && pad_out[RD_BIT] == xmem_rd_n
                     && pad_out[WR_BIT] == xmem_wr_n && !pad_pu[RD_BIT] && !pad_pu[WR_BIT]));

    a_r7_timer_output: assert property (@(posedge clk) disable iff (rst)
        (tmr_oc_en && dir_q[OC_BIT]) |-> pad_out[OC_BIT] == tmr_oc_val);

    a_r3_pin_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_PIN) |=> ($stable(latch_q) && $stable(dir_q)));

    a_r8_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == '0);

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr != A_PIN && bus_addr != A_DIR && bus_addr != A_LATCH)
        |=> bus_rdata == '0);
endmodule

bind gpio_port8 gpio_port8_chk u_chk (.*);

// File: tb/sim_gpio_port8.sv
module sim_gpio_port8;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out, pad_pu;
    logic        xmem_en = 1'b0, xmem_rd_n = 1'b1, xmem_wr_n = 1'b1;
    logic        tmr_oc_en = 1'b0, tmr_oc_val = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] m_lat = '0;
    logic [7:0] m_dir = '0;

    always #10 clk = ~clk;

    gpio_port8 u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #3000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    // one bus cycle: drive after negedge, sample at next negedge
    task automatic bus_cycle(input logic [5:0] a, input logic we, input logic [7:0] d, input logic re);
        bus_addr = a; bus_we = we; bus_wdata = d; bus_re = re;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        if (we && a == 6'h12) m_lat = d;
        if (we && a == 6'h11) m_dir = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_pads(input string tag);
        logic [7:0] eo, ev, ep;
        for (int i = 0; i < 8; i++) begin
            eo[i] = m_dir[i];
            ev[i] = m_lat[i];
            ep[i] = !m_dir[i] && m_lat[i];
        end
        if (tmr_oc_en && m_dir[5]) ev[5] = tmr_oc_val;
        if (xmem_en) begin
            eo[7] = 1'b1; ev[7] = xmem_rd_n; ep[7] = 1'b0;
            eo[6] = 1'b1; ev[6] = xmem_wr_n; ep[6] = 1'b0;
        end
        check({tag, " oe"}, pad_oe, eo);
        check({tag, " out"}, pad_out & eo, ev & eo);
        check({tag, " pu"}, pad_pu, ep);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        bus_cycle(6'h12, 0, 0, 1); check("R1 latch reset", bus_rdata, 8'h00);
        bus_cycle(6'h11, 0, 0, 1); check("R1 dir reset", bus_rdata, 8'h00);
        check_pads("R1 pads after reset");

        // R2 write/readback
        bus_cycle(6'h12, 1, 8'hA5, 0);
        bus_cycle(6'h11, 1, 8'h3C, 0);
        bus_cycle(6'h12, 0, 0, 1); check("R2 latch readback", bus_rdata, 8'hA5);
        bus_cycle(6'h11, 0, 0, 1); check("R2 dir readback", bus_rdata, 8'h3C);
        check_pads("R4 mixed modes");

        // R3 pin-address write ignored
        bus_cycle(6'h10, 1, 8'hFF, 0);
        bus_cycle(6'h12, 0, 0, 1); check("R3 latch kept", bus_rdata, 8'hA5);
        bus_cycle(6'h11, 0, 0, 1); check("R3 dir kept", bus_rdata, 8'h3C);

        // R3 synchronizer latency
        pad_in = 8'h00; idle(3);
        pad_in = 8'h96; idle(1);
        bus_cycle(6'h10, 0, 0, 1); check("R3 one idle old", bus_rdata, 8'h00);
        bus_cycle(6'h10, 0, 0, 1); check("R3 two idle new", bus_rdata, 8'h96);

        // R8 unmapped and idle
        bus_cycle(6'h13, 0, 0, 1); check("R8 unmapped", bus_rdata, 8'h00);
        bus_cycle(6'h12, 0, 0, 0); check("R8 no read", bus_rdata, 8'h00);

        // R9 same-cycle read and write
        bus_cycle(6'h12, 1, 8'h5A, 1); check("R9 old value", bus_rdata, 8'hA5);
        bus_cycle(6'h12, 0, 0, 1); check("R9 new value", bus_rdata, 8'h5A);

        // R7 timer: no effect as input, drives as output
        tmr_oc_en = 1'b1; tmr_oc_val = 1'b1;
        bus_cycle(6'h11, 1, 8'h00, 0);
        bus_cycle(6'h12, 1, 8'h00, 0);
        #1 check("R7 timer ignored oe", pad_oe[5], 1'b0);
        check("R7 timer ignored pu", pad_pu[5], 1'b0);
        bus_cycle(6'h11, 1, 8'h20, 0);
        #1 check("R7 timer drives", pad_out[5], 1'b1);
        tmr_oc_val = 1'b0; #1 check("R7 timer drives low", pad_out[5], 1'b0);
        tmr_oc_en = 1'b0;

        // R6 external memory strobes over pull-up config
        bus_cycle(6'h12, 1, 8'hFF, 0);
        xmem_en = 1'b1; xmem_rd_n = 1'b0; xmem_wr_n = 1'b1; #1;
        check_pads("R6 xmem strobes");
        xmem_en = 1'b0;

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            xmem_en = ($urandom % 4) == 0;
            xmem_rd_n = $urandom; xmem_wr_n = $urandom;
            tmr_oc_en = $urandom; tmr_oc_val = $urandom;
            pad_in = $urandom;
            idle(2);
            op = $urandom % 5;
            case (op)
                0: begin bus_cycle(6'h12, 1, 8'($urandom), 0); check_pads("R4 rand latch"); end
                1: begin bus_cycle(6'h11, 1, 8'($urandom), 0); check_pads("R4 rand dir"); end
                2: begin bus_cycle(6'h10, 0, 0, 1); check("R3 rand pin", bus_rdata, pad_in); end
                3: begin bus_cycle(6'h12, 0, 0, 1); check("R2 rand latch", bus_rdata, m_lat); end
                default: begin bus_cycle(6'h11, 0, 0, 1); check("R2 rand dir", bus_rdata, m_dir); end
            endcase
        end

        // R5 asynchronous reset with all pins driving
        xmem_en = 1'b0; tmr_oc_en = 1'b0;
        bus_cycle(6'h11, 1, 8'hFF, 0);
        bus_cycle(6'h12, 1, 8'hFF, 0);
        #2 rst = 1'b1; #1;
        check("R5 oe cleared at once", pad_oe, 8'h00);
        check("R5 pu cleared at once", pad_pu, 8'h00);
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        bus_cycle(6'h11, 0, 0, 1); check("R1 dir after reset", bus_rdata, 8'h00);

        finish_run();
    end
endmodule